// File: doc/BRIEF.md
# Flash Block-Erase Sequencer

This block runs a complete single-block erase on a byte-wide parallel flash device on behalf of a host. After one start pulse that carries a block address, it works through the full flow by itself. It writes the two-byte erase command and reads the status byte until the device reports ready. It then sorts the outcome into success or one of several failure classes. After a failure it clears the status and tries again, up to a fixed number of times. Once the attempts are over, it writes the read-array command so the device can be read normally.

When the device reports that the programming voltage was too low, the retry first lifts write protection. When the operation finishes, protection is restored if the caller asked for that at start. A status poll that never sees the ready bit ends with a timeout instead of hanging. Every bus cycle holds its write or output strobe low for a fixed number of clocks and then releases it for at least one clock. Each status read is therefore a fresh strobe pulse, and the device refreshes the value it presents.

The result is given as a one-cycle `done` pulse together with one of five flags. The flag stays valid until the next start.

Top module: `blk_erase_seq`

## Requirements
- R1: After reset the block is idle: `busy` and `done` are 0, both strobes are high and all five result flags are 0.
- R2: Each erase attempt writes byte 20h and then byte D0h. The D0h write carries the block address latched at start.
- R3: Each bus cycle drives its strobe (write strobe for writes, output strobe for reads) low for exactly CYC_CLKS clocks. Address and write data stay stable while the strobe is low. The two strobes are never low together, and a strobe is high for at least one clock between cycles.
- R4: After D0h the block performs status reads, each a separate strobe pulse, until a read returns bit 7 = 1.
- R5: A ready status is classified in this order: bits 5 and 4 both 1 is a sequence error; exactly one of bits 5 or 4 set is an erase error; otherwise bit 3 = 1 is a voltage-low error; otherwise the erase succeeded. Bits 6 and 2..0 are ignored.
- R6: After an erase error or a sequence error with retries left, the block writes the clear-status command (default 50h) and then starts a new erase attempt directly.
- R7: After a voltage-low error with retries left, the block writes the clear-status command, then the protection-release command (default 47h), then starts a new erase attempt.
- R8: If `relock_en` was 1 at start and at least one protection release was written, exactly one protection-set command (default 57h) is written after the last attempt and before the final read-array write. Otherwise none is written.
- R9: At most MAX_RETRY retries follow the first attempt. When they are used up, the block finishes and reports the error class of the last attempt, with no clear-status write after that attempt.
- R10: If POLL_LIMIT consecutive status reads in one attempt all return bit 7 = 0, the block reports a timeout and makes no further attempt.
- R11: The last write of every operation is FFh. `done` is high for one clock. In that clock exactly one result flag is 1, and that flag holds until the next accepted start.
- R12: A start pulse while `busy` is 1 is ignored. The block address and the course of the running operation do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start pulse, accepted while idle |
| blk_addr | input | AW | Address of the block to erase |
| relock_en | input | 1 | Restore write protection at the end if it was released |
| fl_din | input | 8 | Data read from the flash |
| fl_addr | output | AW | Flash address |
| fl_dout | output | 8 | Data written to the flash |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Output strobe, active low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Erase succeeded |
| err_erase | output | 1 | Erase error reported |
| err_seq | output | 1 | Command sequence error reported |
| err_vpp | output | 1 | Programming voltage low reported |
| err_timeout | output | 1 | Ready bit never seen |

## Verification
A bench model of the flash answers the strobes. For each attempt it is set up with a busy length and an outcome. The outcomes are success, bit 5 only, bit 4 only, both bits, bit 3, or never ready. Noise is placed in the ignored status bits. Sequences that mix outcomes across attempts separate a retry after a sequence error or erase error, which goes straight to a new erase, from a voltage-low retry, which needs the protection release and later the optional re-lock. Runs where every attempt fails separate the final attempt, which gets no clear, from the earlier ones. Never-ready runs separate a timeout from a normal error. A start pulse injected mid-operation with a different address shows whether an overlapping start can redirect the erase.

// File: rtl/bes_pkg.sv
package bes_pkg;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;

  // status bit positions the classifier depends on
  localparam int SB_READY = 7;
  localparam int SB_ERS   = 5;
  localparam int SB_WRS   = 4;
  localparam int SB_VLOW  = 3;

  typedef enum logic [2:0] {
    RES_NONE, RES_OK, RES_ERASE, RES_SEQ, RES_VPP, RES_TMO
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_CONF, S_POLL, S_CLR, S_WPRST, S_WPSET, S_ARRAY
  } seq_state_e;
endpackage

// File: rtl/bes_rst_sync.sv
module bes_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/bes_bus_cycle.sv
module bes_bus_cycle #(
  parameter int AW       = 19,
  parameter int CYC_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          is_rd,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    data_in,
  input  logic [7:0]    fl_din,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [7:0]    rd_data,
  output logic          cyc_done
);
  localparam int CW = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_CLKS - 1);

  typedef enum logic [1:0] {BC_IDLE, BC_ACT, BC_GAP} bc_e;

  bc_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_q, rd_d;
  logic [AW-1:0] addr_d;
  logic [7:0]    dout_d, rdat_d;
  logic          we_d, oe_d;
  logic          upd;

  assign upd      = (st_q != BC_IDLE) || go;
  assign cyc_done = (st_q == BC_GAP);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rd_d   = rd_q;
    addr_d = fl_addr;
    dout_d = fl_dout;
    rdat_d = rd_data;
    we_d   = fl_we_n;
    oe_d   = fl_oe_n;
    case (st_q)
      BC_IDLE: if (go) begin
        st_d   = BC_ACT;
        cnt_d  = '0;
        rd_d   = is_rd;
        addr_d = addr_in;
        dout_d = data_in;
        we_d   = is_rd;
        oe_d   = ~is_rd;
      end
      BC_ACT: begin
        if (cnt_q == LAST) begin
          st_d = BC_GAP;
          we_d = 1'b1;
          oe_d = 1'b1;
          if (rd_q) rdat_d = fl_din;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = BC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= BC_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      fl_addr <= '0;
      fl_dout <= '0;
      rd_data <= '0;
      fl_we_n <= 1'b1;
      fl_oe_n <= 1'b1;
    end else if (upd) begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      fl_addr <= addr_d;
      fl_dout <= dout_d;
      rd_data <= rdat_d;
      fl_we_n <= we_d;
      fl_oe_n <= oe_d;
    end
  end
endmodule

// File: rtl/bes_status_decode.sv
module bes_status_decode
  import bes_pkg::*;
(
  input  logic [7:0] status,
  output logic       ready,
  output res_e       cls
);
  logic unused_bits;
  assign unused_bits = ^{status[6], status[2:0]};
  assign ready = status[SB_READY];

  always_comb begin
    if (status[SB_ERS] && status[SB_WRS])      cls = RES_SEQ;
    else if (status[SB_ERS] || status[SB_WRS]) cls = RES_ERASE;
    else if (status[SB_VLOW])                  cls = RES_VPP;
    else                                       cls = RES_OK;
  end
endmodule

// File: rtl/blk_erase_seq.sv
module blk_erase_seq
  import bes_pkg::*;
#(
  parameter int          AW         = 19,
  parameter int          CYC_CLKS   = 2,
  parameter int          MAX_RETRY  = 3,
  parameter int          POLL_LIMIT = 4096,
  parameter logic [7:0]  CMD_CLR    = 8'h50,
  parameter logic [7:0]  CMD_WP_RST = 8'h47,
  parameter logic [7:0]  CMD_WP_SET = 8'h57
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] blk_addr,
  input  logic          relock_en,
  input  logic [7:0]    fl_din,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dout,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic          err_erase,
  output logic          err_seq,
  output logic          err_vpp,
  output logic          err_timeout
);
  localparam int RW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
  localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [RW-1:0] RETRY_INIT = RW'(MAX_RETRY);
  localparam logic [PW-1:0] POLL_LAST  = PW'(POLL_LIMIT - 1);

  logic          rst_sync_n;
  seq_state_e    st_q, st_d, end_st;
  logic          launched_q, launched_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          relock_q, relock_d, wprst_q, wprst_d;
  logic [RW-1:0] retry_q, retry_d;
  logic [PW-1:0] poll_q, poll_d;
  res_e          res_q, res_d, cls;
  logic          valid_q, valid_d, done_d;
  logic          go, is_rd, cyc_done, ready;
  logic [7:0]    cmd, rd_data;

  bes_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  bes_bus_cycle #(.AW(AW), .CYC_CLKS(CYC_CLKS)) u_bus (
    .clk(clk), .rst_n(rst_sync_n), .go(go), .is_rd(is_rd),
    .addr_in(addr_q), .data_in(cmd), .fl_din(fl_din),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .rd_data(rd_data), .cyc_done(cyc_done)
  );

  bes_status_decode u_dec (.status(rd_data), .ready(ready), .cls(cls));

  assign go     = (st_q != S_IDLE) && !launched_q;
  assign is_rd  = (st_q == S_POLL);
  assign end_st = (wprst_q && relock_q) ? S_WPSET : S_ARRAY;

  always_comb begin
    case (st_q)
      S_SETUP: cmd = OP_ERASE_SETUP;
      S_CONF:  cmd = OP_ERASE_GO;
      S_CLR:   cmd = CMD_CLR;
      S_WPRST: cmd = CMD_WP_RST;
      S_WPSET: cmd = CMD_WP_SET;
      S_ARRAY: cmd = OP_READ_ARRAY;
      default: cmd = 8'h00;
    endcase
  end

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    relock_d   = relock_q;
    wprst_d    = wprst_q;
    retry_d    = retry_q;
    poll_d     = poll_q;
    res_d      = res_q;
    valid_d    = valid_q;
    done_d     = 1'b0;
    launched_d = cyc_done ? 1'b0 : (go ? 1'b1 : launched_q);
    if (st_q == S_IDLE) begin
      if (start) begin
        st_d     = S_SETUP;
        addr_d   = blk_addr;
        relock_d = relock_en;
        wprst_d  = 1'b0;
        retry_d  = RETRY_INIT;
        valid_d  = 1'b0;
        res_d    = RES_NONE;
      end
    end else if (cyc_done) begin
      case (st_q)
        S_SETUP: st_d = S_CONF;
        S_CONF: begin
          st_d   = S_POLL;
          poll_d = '0;
        end
        S_POLL: begin
          if (!ready) begin
            if (poll_q == POLL_LAST) begin
              res_d = RES_TMO;
              st_d  = end_st;
            end else begin
              poll_d = poll_q + 1'b1;
            end
          end else if (cls == RES_OK) begin
            res_d = RES_OK;
            st_d  = end_st;
          end else begin
            res_d = cls;
            if (retry_q == '0) begin
              st_d = end_st;
            end else begin
              st_d    = S_CLR;
              retry_d = retry_q - 1'b1;
            end
          end
        end
        S_CLR:   st_d = (res_q == RES_VPP) ? S_WPRST : S_SETUP;
        S_WPRST: begin
          wprst_d = 1'b1;
          st_d    = S_SETUP;
        end
        S_WPSET: st_d = S_ARRAY;
        default: begin
          st_d    = S_IDLE;
          done_d  = 1'b1;
          valid_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q       <= S_IDLE;
      launched_q <= 1'b0;
      addr_q     <= '0;
      relock_q   <= 1'b0;
      wprst_q    <= 1'b0;
      retry_q    <= '0;
      poll_q     <= '0;
      res_q      <= RES_NONE;
      valid_q    <= 1'b0;
      done       <= 1'b0;
    end else begin
      st_q       <= st_d;
      launched_q <= launched_d;
      addr_q     <= addr_d;
      relock_q   <= relock_d;
      wprst_q    <= wprst_d;
      retry_q    <= retry_d;
      poll_q     <= poll_d;
      res_q      <= res_d;
      valid_q    <= valid_d;
      done       <= done_d;
    end
  end

  assign busy        = (st_q != S_IDLE);
  assign ok          = valid_q && (res_q == RES_OK);
  assign err_erase   = valid_q && (res_q == RES_ERASE);
  assign err_seq     = valid_q && (res_q == RES_SEQ);
  assign err_vpp     = valid_q && (res_q == RES_VPP);
  assign err_timeout = valid_q && (res_q == RES_TMO);
endmodule

// File: rtl/bes_checker.sv
module bes_checker #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          fl_we_n,
  input logic          fl_oe_n,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_dout,
  input logic          ok,
  input logic          err_erase,
  input logic          err_seq,
  input logic          err_vpp,
  input logic          err_timeout
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_we_n && fl_oe_n));

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  assert_wr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_dout) && $stable(fl_addr)));

  assert_flags_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, err_erase, err_seq, err_vpp, err_timeout}));

  assert_done_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({ok, err_erase, err_seq, err_vpp, err_timeout}) == 1));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> $stable({ok, err_erase, err_seq, err_vpp, err_timeout}));
endmodule

bind blk_erase_seq bes_checker #(.AW(AW)) u_bes_checker (
  .clk(clk), .rst_n(rst_sync_n), .start(start), .busy(busy), .done(done),
  .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_addr(fl_addr), .fl_dout(fl_dout),
  .ok(ok), .err_erase(err_erase), .err_seq(err_seq), .err_vpp(err_vpp),
  .err_timeout(err_timeout)
);

// File: tb/blk_erase_seq_bench.sv
module blk_erase_seq_bench;
  localparam int AW = 19, CYC = 2, MAXR = 3, POLL = 40;

  logic          clk, rst_n, start, relock_en;
  logic [AW-1:0] blk_addr, fl_addr;
  logic [7:0]    fl_din, fl_dout;
  logic          fl_we_n, fl_oe_n, busy, done;
  logic          ok, err_erase, err_seq, err_vpp, err_timeout;

  blk_erase_seq #(.AW(AW), .CYC_CLKS(CYC), .MAX_RETRY(MAXR), .POLL_LIMIT(POLL)) u_blk_erase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr), .relock_en(relock_en),
    .fl_din(fl_din), .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n), .busy(busy), .done(done), .ok(ok), .err_erase(err_erase),
    .err_seq(err_seq), .err_vpp(err_vpp), .err_timeout(err_timeout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // flash model: outcome per attempt 0 ok,1 bit5,5 bit4,2 both,3 bit3,4 never ready
  int codes[4], busyv[4];
  int m_erases, m_clears, m_wprst, m_wpset, m_reads, m_viol, m_addr_err, m_width_err;
  int busy_left, we_run, oe_run;
  logic [7:0] ready_st, last_cmd, noise;
  logic armed, prev_we, prev_oe;
  logic [AW-1:0] exp_addr;

  assign fl_din = (busy_left > 0) ? 8'h00 : ready_st;

  function automatic logic [7:0] st_of(int c);
    case (c)
      0: return 8'h80;
      1: return 8'hA0;
      5: return 8'h90;
      2: return 8'hB0;
      default: return 8'h88;
    endcase
  endfunction

  initial begin
    prev_we = 1'b1; prev_oe = 1'b1; busy_left = 0; ready_st = 8'h80; we_run = 0; oe_run = 0;
    forever begin
      @(negedge clk);
      if (!fl_we_n) we_run++;
      if (!fl_oe_n) oe_run++;
      if (!prev_we && fl_we_n) begin
        if (we_run != CYC) m_width_err++;
        we_run = 0;
        last_cmd = fl_dout;
        if (fl_dout == 8'h20) armed = 1'b1;
        else begin
          if (fl_dout == 8'hD0) begin
            if (!armed) m_viol++;
            if (fl_addr != exp_addr) m_addr_err++;
            if (m_erases < 4) begin
              busy_left = (codes[m_erases] == 4) ? 1000000 : busyv[m_erases];
              ready_st  = st_of(codes[m_erases]) | noise;
            end
            m_erases++;
          end else if (fl_dout == 8'h50) m_clears++;
          else if (fl_dout == 8'h47) m_wprst++;
          else if (fl_dout == 8'h57) m_wpset++;
          armed = 1'b0;
        end
      end
      if (!prev_oe && fl_oe_n) begin
        if (oe_run != CYC) m_width_err++;
        oe_run = 0;
        m_reads++;
        if (busy_left > 0) busy_left--;
      end
      prev_we = fl_we_n;
      prev_oe = fl_oe_n;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int act_res();
    int n;
    n = int'(ok) + int'(err_erase) + int'(err_seq) + int'(err_vpp) + int'(err_timeout);
    if (n != 1) return -1;
    if (ok) return 0;
    if (err_erase) return 1;
    if (err_seq) return 2;
    if (err_vpp) return 3;
    return 4;
  endfunction

  int e_res, e_erases, e_clears, e_wprst, e_wpset, e_reads;

  task automatic calc_expect(input logic relock);
    e_erases = 0; e_clears = 0; e_wprst = 0; e_reads = 0; e_res = 0;
    for (int a = 0; a <= MAXR; a++) begin
      e_erases++;
      if (codes[a] == 4) begin e_reads += POLL; e_res = 4; break; end
      e_reads += busyv[a] + 1;
      if (codes[a] == 0) begin e_res = 0; break; end
      e_res = (codes[a] == 5) ? 1 : codes[a];
      if (a == MAXR) break;
      e_clears++;
      if (codes[a] == 3) e_wprst++;
    end
    e_wpset = (relock && e_wprst > 0) ? 1 : 0;
  endtask

  task automatic run_trial(input logic [AW-1:0] addr, input logic relock, input logic inject);
    m_erases = 0; m_clears = 0; m_wprst = 0; m_wpset = 0; m_reads = 0;
    m_viol = 0; m_addr_err = 0; m_width_err = 0; armed = 1'b0; last_cmd = 8'h00;
    exp_addr = addr;
    calc_expect(relock);
    @(negedge clk);
    start = 1'b1; blk_addr = addr; relock_en = relock;
    @(negedge clk);
    start = 1'b0; blk_addr = ~addr; relock_en = ~relock;
    if (inject) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check("R5 R9 R10 R11 result class", act_res(), e_res);
    check("R2 R6 R9 R10 erase attempts", m_erases, e_erases);
    check("R6 R9 clear writes", m_clears, e_clears);
    check("R7 protection releases", m_wprst, e_wprst);
    check("R8 protection sets", m_wpset, e_wpset);
    check("R4 R10 status reads", m_reads, e_reads);
    check("R11 final command", int'(last_cmd), 32'hFF);
    check("R2 setup before confirm", m_viol, 0);
    check(inject ? "R12 erase address" : "R2 erase address", m_addr_err, 0);
    check("R3 strobe width", m_width_err, 0);
    @(negedge clk);
    check("R11 result held", act_res(), e_res);
    check("R11 done one cycle", int'(done), 0);
  endtask

  task automatic set_att(input int c0, input int c1, input int c2, input int c3, input int b);
    codes[0] = c0; codes[1] = c1; codes[2] = c2; codes[3] = c3;
    for (int i = 0; i < 4; i++) busyv[i] = b + i;
  endtask

  initial begin
    void'($urandom(32'd5150));
    start = 1'b0; blk_addr = '0; relock_en = 1'b0; rst_n = 1'b0; noise = 8'h00;
    set_att(0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 strobes", int'({fl_we_n, fl_oe_n}), 3);
    check("R1 flags", int'({ok, err_erase, err_seq, err_vpp, err_timeout}), 0);

    set_att(0, 0, 0, 0, 0);  run_trial(19'h0C000, 1'b1, 1'b0);
    set_att(2, 0, 0, 0, 3);  run_trial(19'h14000, 1'b1, 1'b0);
    set_att(5, 1, 5, 1, 1);  run_trial(19'h3C000, 1'b0, 1'b0);
    set_att(3, 0, 0, 0, 2);  run_trial(19'h04000, 1'b1, 1'b0);
    set_att(3, 0, 0, 0, 2);  run_trial(19'h04000, 1'b0, 1'b0);
    set_att(3, 3, 3, 3, 0);  run_trial(19'h7C000, 1'b1, 1'b0);
    set_att(4, 0, 0, 0, 0);  run_trial(19'h00000, 1'b1, 1'b0);
    set_att(1, 4, 0, 0, 1);  run_trial(19'h28000, 1'b0, 1'b0);
    set_att(1, 0, 0, 0, 4);  run_trial(19'h18000, 1'b0, 1'b1);
    noise = 8'h47;
    set_att(0, 0, 0, 0, 1);  run_trial(19'h08000, 1'b0, 1'b0);

    for (int t = 0; t < 50; t++) begin
      for (int a = 0; a < 4; a++) begin
        int r;
        r = int'($urandom % 10);
        codes[a] = (r < 4) ? 0 : (r == 4) ? 1 : (r == 5) ? 5 : (r == 6) ? 2 : (r < 9) ? 3 : 4;
        busyv[a] = int'($urandom % 11);
      end
      noise = 8'($urandom) & 8'h47;
      run_trial(AW'($urandom) & 19'h7C000, 1'($urandom), 1'($urandom % 4 == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule